// File: doc/BRIEF.md
# Iterative Integer Divider with Signed and Unsigned Modes

This block divides one W-bit integer by another and returns a W-bit quotient and a W-bit remainder. It works serially. A restoring shift-subtract core finds one quotient bit per clock cycle from the operand magnitudes. One more cycle then gives the quotient and the remainder their signs. The mode input chooses between unsigned and two's-complement signed operation. Every operand pair gives a defined result, including a zero divisor and the most negative signed dividend.

Operation is a start/busy/done exchange. When `start` is high and the block is not busy, the operands and the mode are captured on that clock edge. `busy` stays high while the divider iterates. `done` then stays high, and the results hold, until the next start is accepted. A zero divisor skips the iteration: its fixed result is written on the capture edge.

The controller has four states:
- `DS_IDLE`: waiting after reset.
- `DS_ITER`: W shift-subtract steps.
- `DS_SIGN`: one cycle of sign correction.
- `DS_HOLD`: results valid.

Its transitions:
- From `DS_IDLE` or `DS_HOLD`, an accepted start goes to `DS_ITER` if the divisor is nonzero, and to `DS_HOLD` if the divisor is zero.
- `DS_ITER` goes to `DS_SIGN` after its last step.
- `DS_SIGN` always goes to `DS_HOLD`.
- Without a start, `DS_IDLE` and `DS_HOLD` stay where they are.

Top module: `intdiv_seq`

## Requirements
- R1: With `signed_mode`=0, the divider treats the operands as unsigned. For a nonzero divisor the quotient is the truncated quotient and the remainder is dividend minus quotient times divisor. The remainder is always below the divisor.
- R2: With `signed_mode`=1, the divider treats the operands as two's complement. For a nonzero divisor the quotient is the exact quotient rounded toward zero.
- R3: In signed mode with a nonzero divisor, the remainder is dividend minus quotient times divisor. A nonzero remainder has the sign of the dividend, and its magnitude is below the divisor's magnitude.
- R4: An unsigned division by zero returns a quotient of all ones and a remainder of 0.
- R5: A signed division by zero returns the largest positive value (0 followed by ones) when the dividend is zero or positive. It returns the most negative value (1 followed by zeros) when the dividend is negative. The remainder is 0 in both cases.
- R6: In signed mode, the most negative value divided by -1 gives the most negative value as the quotient and 0 as the remainder.
- R7: For a nonzero divisor, `busy` is high from the capture edge onwards. `done` rises on the (W+2)-th rising edge, counting the capture edge as the first. `busy` and `done` are never high together.
- R8: For a zero divisor, `done` is high and `busy` is low right after the capture edge.
- R9: While `busy` is high, `start` and any changes on the operand or mode inputs are ignored. The running division completes with the captured values and the normal latency.
- R10: While `done` is high and `start` is low, `done`, `quotient` and `remainder` hold their values. A start in that state is accepted and begins a new division.
- R11: After reset, `busy`, `done`, `quotient` and `remainder` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to capture operands and begin a division |
| signed_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | W | Numerator operand |
| divisor | input | W | Denominator operand |
| busy | output | 1 | Division in progress |
| done | output | 1 | Results valid |
| quotient | output | W | Quotient result |
| remainder | output | W | Remainder result |

## Verification
The assertions rely on the inputs being driven only between clock edges. They also take it that reset is held across at least one edge, so no property sees the values before reset. The remainder checks additionally assume W is at least 2, because the core's shift register needs two bits. The bench meets these conditions by changing every input on the falling edge. It runs a four-bit instance through every dividend, divisor and mode combination, which includes both zero-divisor cases and the most-negative-by-minus-one case. It also drives stray start pulses and operand changes during a running division.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;

    typedef enum logic [1:0] {
        DS_IDLE = 2'd0,
        DS_ITER = 2'd1,
        DS_SIGN = 2'd2,
        DS_HOLD = 2'd3
    } div_state_e;

endpackage

// File: rtl/intdiv_prep.sv
module intdiv_prep #(
    parameter int W = 8
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         signed_mode,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg_a,
    output logic         neg_b,
    output logic         div_zero
);
    // A negative value is one whose top bit is set, and only in signed mode.
    always_comb begin
        neg_a    = signed_mode & dividend[W-1];
        neg_b    = signed_mode & divisor[W-1];
        // The magnitude of the most negative value is 2^(W-1), which W unsigned bits still hold.
        mag_a    = neg_a ? (~dividend + 1'b1) : dividend;
        mag_b    = neg_b ? (~divisor + 1'b1) : divisor;
        div_zero = (divisor == '0);
    end
endmodule

// File: rtl/intdiv_core.sv
module intdiv_core #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] mag_a,
    input  logic [W-1:0] mag_b,
    output logic [W-1:0] quo_mag,
    output logic [W-1:0] rem_mag,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_r;
    logic [W-1:0]  quo_r;
    logic [W-1:0]  dvs_r;
    logic [CW-1:0] cnt_r;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    // Bring down the next dividend bit, then try to subtract the divisor.
    always_comb begin
        shifted = {rem_r, quo_r[W-1]};
        trial   = shifted - {1'b0, dvs_r};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_r <= '0;
            quo_r <= '0;
            dvs_r <= '0;
            cnt_r <= '0;
        end else if (load) begin
            rem_r <= '0;
            quo_r <= mag_a;
            dvs_r <= mag_b;
            cnt_r <= CW'(W);
        end else if (step) begin
            if (!trial[W]) begin
                rem_r <= trial[W-1:0];
                quo_r <= {quo_r[W-2:0], 1'b1};
            end else begin
                rem_r <= shifted[W-1:0];
                quo_r <= {quo_r[W-2:0], 1'b0};
            end
            cnt_r <= cnt_r - CW'(1);
        end
    end

    always_comb begin
        quo_mag = quo_r;
        rem_mag = rem_r;
        last    = (cnt_r == CW'(1));
    end

    // After the final step the partial remainder lies below the divisor.
    assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last) |=> (rem_r < dvs_r));

    // A step is only requested while steps remain.
    assert_step_has_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_r != '0));

    // The captured divisor does not change between loads.
    assert_divisor_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(dvs_r));
endmodule

// File: rtl/intdiv_fix.sv
module intdiv_fix #(
    parameter int W = 8
) (
    input  logic [W-1:0] quo_mag,
    input  logic [W-1:0] rem_mag,
    input  logic         neg_a,
    input  logic         neg_b,
    output logic [W-1:0] quo_out,
    output logic [W-1:0] rem_out
);
    logic neg_q;

    // The quotient is negative when the operand signs differ.
    // The remainder takes the sign of the dividend.
    always_comb begin
        neg_q   = neg_a ^ neg_b;
        quo_out = neg_q ? (~quo_mag + 1'b1) : quo_mag;
        rem_out = neg_a ? (~rem_mag + 1'b1) : rem_mag;
    end
endmodule

// File: rtl/intdiv_seq.sv
module intdiv_seq
    import intdiv_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         signed_mode,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    div_state_e   state_q, state_d;
    logic [W-1:0] mag_a, mag_b, quo_mag, rem_mag, quo_fix, rem_fix;
    logic         neg_a, neg_b, div_zero, last;
    logic         neg_a_q, neg_b_q, sgn_q;
    logic         accept;
    logic [W-1:0] quo_q, rem_q;
    logic [W-1:0] zq;

    intdiv_prep #(.W(W)) prep_i (
        .dividend(dividend), .divisor(divisor), .signed_mode(signed_mode),
        .mag_a(mag_a), .mag_b(mag_b), .neg_a(neg_a), .neg_b(neg_b),
        .div_zero(div_zero)
    );

    intdiv_core #(.W(W)) core_i (
        .clk(clk), .rst_n(rst_n),
        .load(accept && !div_zero), .step(state_q == DS_ITER),
        .mag_a(mag_a), .mag_b(mag_b),
        .quo_mag(quo_mag), .rem_mag(rem_mag), .last(last)
    );

    intdiv_fix #(.W(W)) fix_i (
        .quo_mag(quo_mag), .rem_mag(rem_mag),
        .neg_a(neg_a_q), .neg_b(neg_b_q),
        .quo_out(quo_fix), .rem_out(rem_fix)
    );

    // A start is taken only outside the iteration and sign states.
    always_comb begin
        accept = start && (state_q == DS_IDLE || state_q == DS_HOLD);
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE, DS_HOLD: if (accept) state_d = div_zero ? DS_HOLD : DS_ITER;
            DS_ITER:          if (last) state_d = DS_SIGN;
            DS_SIGN:          state_d = DS_HOLD;
            default:          state_d = DS_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_IDLE;
        else        state_q <= state_d;
    end

    // Fixed quotient for a zero divisor.
    always_comb begin
        if (!signed_mode) zq = '1;
        else if (neg_a)   zq = SMIN;
        else              zq = SMAX;
    end

    // Captured sign flags and the result registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            neg_a_q <= 1'b0;
            neg_b_q <= 1'b0;
            sgn_q   <= 1'b0;
            quo_q   <= '0;
            rem_q   <= '0;
        end else if (accept) begin
            neg_a_q <= neg_a;
            neg_b_q <= neg_b;
            sgn_q   <= signed_mode;
            if (div_zero) begin
                quo_q <= zq;
                rem_q <= '0;
            end
        end else if (state_q == DS_SIGN) begin
            quo_q <= quo_fix;
            rem_q <= rem_fix;
        end
    end

    // Output decode.
    always_comb begin
        busy      = (state_q == DS_ITER) || (state_q == DS_SIGN);
        done      = (state_q == DS_HOLD);
        quotient  = quo_q;
        remainder = rem_q;
    end

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_zero_div_fast_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && div_zero) |=> (done && !busy && remainder == '0));

    assert_unsigned_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && div_zero && !signed_mode) |=> (quotient == '1));

    assert_hold_results_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(quotient) && $stable(remainder)));

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(sgn_q) && $stable(neg_a_q) && $stable(neg_b_q)));

    assert_rem_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DS_SIGN && sgn_q && rem_mag != '0) |=> (remainder[W-1] == neg_a_q));
endmodule

// File: tb/intdiv_seq_tb.sv
module intdiv_seq_tb_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         signed_mode = 1'b0;
    logic [W-1:0] dividend = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done;
    logic [W-1:0] quotient, remainder;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    intdiv_seq #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .signed_mode(signed_mode),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    function automatic int sx(input int v);
        return (v >= (1 << (W-1))) ? v - (1 << W) : v;
    endfunction

    task automatic expect_of(input int md, input int a, input int b, output int eq, output int er);
        int sa, sb;
        if (md == 0) begin
            if (b == 0) begin eq = (1 << W) - 1; er = 0; end
            else begin eq = a / b; er = a % b; end
        end else begin
            sa = sx(a); sb = sx(b);
            if (b == 0) begin eq = (sa < 0) ? (1 << (W-1)) : (1 << (W-1)) - 1; er = 0; end
            else begin eq = (sa / sb) & ((1 << W) - 1); er = (sa % sb) & ((1 << W) - 1); end
        end
    endtask

    // Wait until done; return the number of rising edges counted from the capture edge.
    task automatic wait_done(output int edges);
        edges = 1;
        while (!done && edges < 64) begin
            @(posedge clk); @(negedge clk);
            edges++;
        end
    endtask

    task automatic run_op(input int md, input int a, input int b);
        int eq, er, edges;
        string tq, tr;
        expect_of(md, a, b, eq, er);
        if (b == 0) begin tq = (md == 0) ? "R4" : "R5"; tr = tq; end
        else if (md == 0) begin tq = "R1"; tr = "R1"; end
        else if (sx(a) == -(1 << (W-1)) && sx(b) == -1) begin tq = "R6"; tr = "R6"; end
        else begin tq = "R2"; tr = "R3"; end
        signed_mode = md[0];
        dividend = a[W-1:0];
        divisor = b[W-1:0];
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        if (b == 0) begin
            check("R8 busy after zero-divisor capture", int'(busy), 0);
            check("R8 done after zero-divisor capture", int'(done), 1);
        end else begin
            check("R7 busy after capture", int'(busy), 1);
            check("R10 done drops on new start", int'(done), 0);
        end
        wait_done(edges);
        check(b == 0 ? "R8 latency" : "R7 latency", edges, (b == 0) ? 1 : W + 2);
        check(tq, int'(quotient), eq);
        check(tr, int'(remainder), er);
    endtask

    initial begin
        int edges;
        @(negedge clk);
        check("R11 busy reset", int'(busy), 0);
        check("R11 done reset", int'(done), 0);
        check("R11 quotient reset", int'(quotient), 0);
        check("R11 remainder reset", int'(remainder), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Every mode, dividend and divisor of the small configuration.
        for (int md = 0; md < 2; md++)
            for (int a = 0; a < (1 << W); a++)
                for (int b = 0; b < (1 << W); b++)
                    run_op(md, a, b);

        // R9: stray start and changed operands while busy are ignored.
        signed_mode = 1'b0; dividend = 4'd13; divisor = 4'd3; start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        @(posedge clk); @(negedge clk);
        start = 1'b1; signed_mode = 1'b1; dividend = 4'd2; divisor = 4'd0;
        @(posedge clk); @(negedge clk);
        start = 1'b0; dividend = 4'd7; divisor = 4'd1;
        edges = 3;
        while (!done && edges < 64) begin
            @(posedge clk); @(negedge clk);
            edges++;
        end
        check("R9 latency unchanged", edges, W + 2);
        check("R9 quotient", int'(quotient), 4);
        check("R9 remainder", int'(remainder), 1);

        // R10: results hold while idle in the done state with inputs moving.
        for (int i = 0; i < 5; i++) begin
            dividend = 4'(i + 5); divisor = 4'(i); signed_mode = i[0];
            @(posedge clk); @(negedge clk);
        end
        check("R10 done held", int'(done), 1);
        check("R10 quotient held", int'(quotient), 4);
        check("R10 remainder held", int'(remainder), 1);

        finish_run();
    end
endmodule